// File: doc/BRIEF.md
# Endpoint Polling Interval Timer

This block serves one direction of one endpoint in a host-side bus controller. When a transfer on that endpoint ends, it works out from the endpoint's attribute nibble and its interval value how long to wait before the transfer is tried again. That wait is counted in microframe units of 1/8000 s. A microframe tick input drives the countdown. When the count runs out, the block raises a one-cycle callback strobe, and the packet engine outside the block uses that strobe to issue the next packet.

The wait grows exponentially with the interval value. Control, bulk and isochronous endpoints at any speed other than high speed get an extra factor of eight. The timer is armed when a transfer is answered with NAK. It is also armed after every completion on an interrupt endpoint. Any software write to the interval register or to the control/status register of that direction cancels a pending wait.

Top module: `ep_poll_timer`

## Requirements
- R1: After reset the timer is idle (`timer_busy` low) and `cb_fire` is low.
- R2: The attribute nibble `ep_attr` holds the speed in bits 3:2 and the transfer type in bits 1:0. Speed code 2 means high speed and every other code is non-high speed. Type codes are 0 control, 1 isochronous, 2 bulk and 3 interrupt. For a control, bulk or isochronous endpoint at high speed, the wait is 2^(v-1) ticks, where v is `ep_ival`.
- R3: For a control, bulk or isochronous endpoint at non-high speed, the wait is 8·2^(v-1) ticks.
- R4: For an interrupt endpoint the wait is 2^(v-1) ticks at every speed. When `ep_zero` is high, the type field is ignored and the endpoint is handled as control.
- R5: A `xfer_done` pulse arms the timer if `xfer_nak` is high or the endpoint is an interrupt endpoint. Otherwise the timer stays idle.
- R6: An interval value of 0 means there is no wait, so the timer never arms.
- R7: `reg_wr_cancel` clears a pending wait, and no strobe follows it. If a cancel and an arm fall in the same cycle, the cancel wins.
- R8: `cb_fire` is high for exactly one cycle. It rises in the cycle after the edge that sampled the final counted tick, and `timer_busy` falls in that same cycle. A tick in the arming cycle is not counted.
- R9: If an arm coincides with the final tick, the counter reloads with the new wait and no strobe is raised for the old one.
- R10: When the exponent reaches `CNT_W` or more, the wait saturates at 2^CNT_W − 1 ticks.
- R11: An arm while a wait is running restarts the count with the newly computed wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uframe_tick | input | 1 | One-cycle pulse per microframe |
| ep_attr | input | 4 | Speed in bits 3:2, transfer type in bits 1:0 |
| ep_ival | input | IVAL_W | Interval exponent value |
| ep_zero | input | 1 | Endpoint is the default control endpoint |
| xfer_done | input | 1 | Transfer completion pulse |
| xfer_nak | input | 1 | Completion was a NAK, qualified by `xfer_done` |
| reg_wr_cancel | input | 1 | Interval or control/status register was written |
| cb_fire | output | 1 | Callback strobe on expiry |
| timer_busy | output | 1 | A wait is pending |

## Verification
The assertions check the following on every cycle:
- the strobe lasts one cycle and only ever follows a tick;
- a cancel leaves the timer idle and silent;
- a zero interval or a non-NAK bulk completion never arms the timer;
- an arm on the final tick suppresses the strobe.

Only the bench scenarios can show that the exact wait lengths match the exponential formula, including the factor of eight and saturation. The same applies to the endpoint-zero override and to a restart of a running count.

// File: rtl/ep_poll_timer.sv
module ep_poll_timer #(
  parameter int CNT_W  = 20,
  parameter int IVAL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uframe_tick,
  input  logic [3:0]        ep_attr,
  input  logic [IVAL_W-1:0] ep_ival,
  input  logic              ep_zero,
  input  logic              xfer_done,
  input  logic              xfer_nak,
  input  logic              reg_wr_cancel,
  output logic              cb_fire,
  output logic              timer_busy
);
  localparam int SH_W = IVAL_W + 2;
  localparam logic [1:0] SPD_HIGH = 2'd2;
  localparam logic [1:0] TT_INTR  = 2'd3;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] wait_len;
  logic [SH_W-1:0]  shamt;

  wire is_intr = !ep_zero && (ep_attr[1:0] == TT_INTR);
  wire slow8   = !is_intr && (ep_attr[3:2] != SPD_HIGH);

  assign shamt = SH_W'(ep_ival) - SH_W'(1) + (slow8 ? SH_W'(3) : SH_W'(0));

  always_comb begin
    if (ep_ival == '0)
      wait_len = '0;
    else if (shamt >= SH_W'(CNT_W))
      wait_len = '1;
    else
      wait_len = CNT_W'(1) << shamt;
  end

  wire arm = xfer_done && (xfer_nak || is_intr) && (wait_len != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      timer_busy <= 1'b0;
      cb_fire    <= 1'b0;
    end else begin
      cb_fire <= 1'b0;
      if (reg_wr_cancel) begin
        timer_busy <= 1'b0;
      end else if (arm) begin
        timer_busy <= 1'b1;
        cnt        <= wait_len;
      end else if (timer_busy && uframe_tick) begin
        if (cnt == CNT_W'(1)) begin
          timer_busy <= 1'b0;
          cb_fire    <= 1'b1;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ep_poll_timer_chk.sv
module ep_poll_timer_chk #(
  parameter int IVAL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              uframe_tick,
  input logic [3:0]        ep_attr,
  input logic [IVAL_W-1:0] ep_ival,
  input logic              ep_zero,
  input logic              xfer_done,
  input logic              xfer_nak,
  input logic              reg_wr_cancel,
  input logic              cb_fire,
  input logic              timer_busy
);
  wire intr_ep = !ep_zero && (ep_attr[1:0] == 2'd3);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cb_fire |=> !cb_fire);

  a_r8_idle_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    cb_fire |-> !timer_busy);

  a_r8_fire_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cb_fire) |-> $past(uframe_tick));

  a_r7_cancel_clears: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_cancel |=> (!timer_busy && !cb_fire));

  a_r6_zero_ival: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && ep_ival == '0 && !timer_busy) |=> !timer_busy);

  a_r5_plain_done: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !xfer_nak && !intr_ep && !timer_busy) |=> !timer_busy);

  a_r9_rearm_at_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_busy && uframe_tick && xfer_done && xfer_nak && ep_ival != '0
     && !reg_wr_cancel) |=> (timer_busy && !cb_fire));
endmodule

bind ep_poll_timer ep_poll_timer_chk #(.IVAL_W(IVAL_W)) u_chk (.*);

// File: tb/sim_ep_poll_timer.sv
module sim_ep_poll_timer;
  localparam int CLK_P = 10;
  localparam int CW = 10;

  logic clk = 0, rst_n = 0, tick = 0, ep0 = 0, done = 0, nak = 0, cancel = 0;
  logic [3:0] attr = 0;
  logic [7:0] ival = 0;
  logic fire, busy;
  int total = 0, bad = 0;
  bit ended = 0;

  always #(CLK_P/2) clk = ~clk;

  ep_poll_timer #(.CNT_W(CW), .IVAL_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .uframe_tick(tick), .ep_attr(attr), .ep_ival(ival),
    .ep_zero(ep0), .xfer_done(done), .xfer_nak(nak), .reg_wr_cancel(cancel),
    .cb_fire(fire), .timer_busy(busy));

  function automatic int exp_delay(logic [1:0] spd, logic [1:0] tt, logic z, int v);
    int sh;
    bit intr;
    if (v == 0) return 0;
    intr = !z && tt == 2'd3;
    sh = v - 1;
    if (!intr && spd != 2'd2) sh = sh + 3;
    if (sh >= CW) return (1 << CW) - 1;
    return 1 << sh;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic arm(logic [1:0] spd, logic [1:0] tt, logic z, int v, logic n);
    attr = {spd, tt}; ep0 = z; ival = v[7:0]; nak = n; done = 1;
    @(negedge clk);
    done = 0; nak = 0;
  endtask

  task automatic run_ticks(int n, string req);
    for (int i = 1; i <= n; i++) begin
      int gap = $urandom % 3;
      repeat (gap) @(negedge clk);
      tick = 1;
      @(negedge clk);
      tick = 0;
      if (i < n) begin
        if (fire !== 1'b0 || busy !== 1'b1) begin
          chk(0, req, {fire, busy}, 1);
          return;
        end
      end
    end
    chk(fire === 1'b1, req, fire, 1);
    chk(busy === 1'b0, req, busy, 0);
    @(negedge clk);
    chk(fire === 1'b0, "R8", fire, 0);
  endtask

  task automatic quiet_ticks(int n, string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      tick = 1; @(negedge clk); tick = 0;
      if (fire) seen = 1;
    end
    chk(!seen && !busy, req, seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && fire === 1'b0, "R1", {busy, fire}, 0);
    rst_n = 1;
    @(negedge clk);

    arm(2'd2, 2'd2, 0, 4, 1);
    chk(busy === 1'b1, "R5", busy, 1);
    run_ticks(8, "R2");
    arm(2'd1, 2'd0, 0, 2, 1);
    run_ticks(16, "R3");
    arm(2'd0, 2'd3, 0, 3, 0);
    run_ticks(4, "R4");
    arm(2'd1, 2'd3, 1, 1, 1);
    run_ticks(8, "R4");
    arm(2'd2, 2'd2, 0, 3, 0);
    chk(busy === 1'b0, "R5", busy, 0);
    quiet_ticks(6, "R5");
    arm(2'd1, 2'd3, 0, 0, 1);
    chk(busy === 1'b0, "R6", busy, 0);
    quiet_ticks(4, "R6");

    arm(2'd2, 2'd1, 0, 4, 1);
    tick = 1; repeat (3) @(negedge clk); tick = 0;
    cancel = 1; @(negedge clk); cancel = 0;
    chk(busy === 1'b0, "R7", busy, 0);
    quiet_ticks(10, "R7");
    cancel = 1; attr = 4'b1010; ival = 2; nak = 1; done = 1;
    @(negedge clk);
    cancel = 0; done = 0; nak = 0;
    chk(busy === 1'b0, "R7", busy, 0);

    arm(2'd2, 2'd2, 0, 2, 1);
    tick = 1; @(negedge clk);
    attr = 4'b1010; ival = 1; nak = 1; done = 1;
    @(negedge clk);
    tick = 0; done = 0; nak = 0;
    chk(fire === 1'b0 && busy === 1'b1, "R9", {fire, busy}, 1);
    run_ticks(1, "R9");

    arm(2'd2, 2'd2, 0, 12, 1);
    run_ticks(1023, "R10");

    arm(2'd2, 2'd2, 0, 4, 1);
    tick = 1; repeat (3) @(negedge clk); tick = 0;
    arm(2'd2, 2'd2, 0, 3, 1);
    run_ticks(4, "R11");

    for (int k = 0; k < 40; k++) begin
      logic [1:0] spd = 2'($urandom % 4);
      logic [1:0] tt = 2'($urandom % 4);
      logic z = ($urandom % 8) == 0;
      logic n = 1'($urandom % 2);
      int v = (($urandom % 8) == 0) ? 0 : 1 + $urandom % 7;
      int d = exp_delay(spd, tt, z, v);
      bit expect_arm = (d != 0) && (n || (!z && tt == 2'd3));
      arm(spd, tt, z, v, n);
      if (expect_arm) run_ticks(d, "R5");
      else begin
        chk(busy === 1'b0, "R5", busy, 0);
        quiet_ticks(3, "R6");
      end
    end
    summary();
  end
endmodule